// File: doc/BRIEF.md
# Spare Row Remapping Logic

This block sits in front of the row decoder of a 514-row SRAM. It receives a logical row address and decides whether the access goes to the normal wordline or to one of four spare rows. The array has two banks. The bottom bank holds rows 0 to 511 and the top bank holds rows 512 and 513. Each bank owns two spare rows of its own. Each spare is programmed with an active-high enable and the address of the faulty row it replaces.

A bottom spare holds a 9-bit row address and can only stand in for a bottom-bank row. A top spare holds a single bit that chooses between row 512 and row 513. When a spare matches, the block drops the normal-row flag and raises a one-hot spare select. If two enabled spares claim the same row, the lowest-numbered spare wins and a multi-hit flag is raised so that a wasted or conflicting repair setting can be detected.

Addresses enter on a valid/ready stream. Results leave on a valid/ready stream through one register stage. An address is taken when `in_valid` and `in_ready` are both high. The result appears on the output one cycle later. While `out_valid` is high and `out_ready` is low, the output holds steady and `in_ready` stays low. The upstream side must then keep its address until it is accepted. When `out_ready` is high, a new address is taken in the same cycle that the previous result drains. This gives one result per cycle. The repair settings are sampled when an address is accepted.

Top module: `rrm_spare_row_remap`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is low and `in_ready` is high.
- R2: An enabled bottom spare k (k = 0 or 1) whose address field `bot_addr[9k+8:9k]` equals the row index replaces any row below 512. For such a row, `out_spare_sel` bit k is high and `out_normal_valid` is low.
- R3: A bottom spare never matches row 512 or 513, even when its 9-bit address equals the low bits of that row. For row 512 or 513, `out_spare_sel[1:0]` is 0.
- R4: An enabled top spare j (j = 0 or 1) matches row 512 when `top_addr[j]` is 0 and row 513 when it is 1, and raises `out_spare_sel[2+j]`. A top spare never matches a row below 512.
- R5: A spare whose enable bit is low has no effect on any output, whatever its address.
- R6: When more than one enabled spare matches, only the lowest-numbered matching select bit is raised and `out_multi_hit` is high. `out_multi_hit` is low otherwise. The select numbering is: bits 0 and 1 for bottom spares 0 and 1, bits 2 and 3 for top spares 0 and 1.
- R7: When no enabled spare matches, `out_normal_valid` is high and `out_spare_sel` is 0.
- R8: A result appears with `out_valid` high in the cycle after its address is accepted. With no accepted address and the previous result drained, `out_valid` is low.
- R9: While `out_valid` is high and `out_ready` is low, all outputs hold steady and `in_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R10: `out_row` equals the row address that was accepted, whether or not it was remapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row address offered |
| in_ready | output | 1 | Block can take an address |
| in_row | input | 10 | Logical row address (word address divided by 16) |
| bot_en | input | 2 | Enables of bottom spares 0 and 1 |
| bot_addr | input | 18 | Faulty-row addresses of the bottom spares, 9 bits each, spare 0 in the low field |
| top_en | input | 2 | Enables of top spares 0 and 1 |
| top_addr | input | 2 | Row-select bits of the top spares (0 selects 512, 1 selects 513) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_normal_valid | output | 1 | Normal wordline is to be used |
| out_row | output | 10 | Row address of this result |
| out_spare_sel | output | 4 | One-hot spare wordline select |
| out_multi_hit | output | 1 | More than one enabled spare matched |

## Verification
The assertions assume that rows above 513 never arrive and that the upstream side does not retract or change an offered address before it is accepted. The bench sweeps only rows 0 to 513. It keeps `in_valid` and `in_row` steady during the back-pressure test until `in_ready` returns. Each full sweep uses fixed repair settings. The settings change only while the pipeline is empty, so a sampled setting can never be mistaken for a later one.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  // Default array geometry: a power-of-two bottom bank and a small top bank
  localparam int DEF_BOT_ROWS   = 512;
  localparam int DEF_TOP_ROWS   = 2;
  localparam int DEF_BOT_SPARES = 2;
  localparam int DEF_TOP_SPARES = 2;

  typedef enum logic {
    BANK_LOWER = 1'b0,
    BANK_UPPER = 1'b1
  } bank_e;
endpackage

// File: rtl/rrm_bank_match.sv
// Compares one bank's spares against the in-bank row index
module rrm_bank_match #(
  parameter int NSP = 2,
  parameter int AW  = 9
) (
  input  logic              bank_hit,
  input  logic [AW-1:0]     row_idx,
  input  logic [NSP-1:0]    sp_en,
  input  logic [NSP*AW-1:0] sp_addr,
  output logic [NSP-1:0]    sp_hit
);
  for (genvar k = 0; k < NSP; k++) begin : g_cmp
    assign sp_hit[k] = bank_hit && sp_en[k] && (sp_addr[k*AW +: AW] == row_idx);
  end
endmodule

// File: rtl/rrm_priority.sv
// Lowest index wins; flags any second contender
module rrm_priority #(
  parameter int N = 4
) (
  input  logic [N-1:0] hits,
  output logic [N-1:0] grant,
  output logic         multi,
  output logic         any
);
  logic [N-1:0] seen;

  for (genvar i = 0; i < N; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign seen[i]  = hits[i];
      assign grant[i] = hits[i];
    end else begin : g_rest
      assign seen[i]  = seen[i-1] | hits[i];
      assign grant[i] = hits[i] & ~seen[i-1];
    end
  end

  assign any   = seen[N-1];
  assign multi = (hits & ~grant) != '0;
endmodule

// File: rtl/rrm_spare_row_remap.sv
module rrm_spare_row_remap
  import rrm_pkg::*;
#(
  parameter int BOT_ROWS   = DEF_BOT_ROWS,
  parameter int TOP_ROWS   = DEF_TOP_ROWS,
  parameter int BOT_SPARES = DEF_BOT_SPARES,
  parameter int TOP_SPARES = DEF_TOP_SPARES,
  localparam int ROW_W  = $clog2(BOT_ROWS + TOP_ROWS),
  localparam int BOT_AW = $clog2(BOT_ROWS),
  localparam int TOP_AW = (TOP_ROWS > 1) ? $clog2(TOP_ROWS) : 1,
  localparam int NSP    = BOT_SPARES + TOP_SPARES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ROW_W-1:0]         in_row,
  input  logic [BOT_SPARES-1:0]    bot_en,
  input  logic [BOT_SPARES*BOT_AW-1:0] bot_addr,
  input  logic [TOP_SPARES-1:0]    top_en,
  input  logic [TOP_SPARES*TOP_AW-1:0] top_addr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_normal_valid,
  output logic [ROW_W-1:0]         out_row,
  output logic [NSP-1:0]           out_spare_sel,
  output logic                     out_multi_hit
);
  // Bank decode: the bottom bank is a power of two, so the top-bank index
  // is simply the low bits of the row address.
  bank_e bank;
  assign bank = (in_row >= ROW_W'(BOT_ROWS)) ? BANK_UPPER : BANK_LOWER;

  logic [BOT_SPARES-1:0] bot_hit;
  logic [TOP_SPARES-1:0] top_hit;

  rrm_bank_match #(.NSP(BOT_SPARES), .AW(BOT_AW)) u_bot (
    .bank_hit (bank == BANK_LOWER),
    .row_idx  (in_row[BOT_AW-1:0]),
    .sp_en    (bot_en),
    .sp_addr  (bot_addr),
    .sp_hit   (bot_hit)
  );

  rrm_bank_match #(.NSP(TOP_SPARES), .AW(TOP_AW)) u_top (
    .bank_hit (bank == BANK_UPPER),
    .row_idx  (in_row[TOP_AW-1:0]),
    .sp_en    (top_en),
    .sp_addr  (top_addr),
    .sp_hit   (top_hit)
  );

  logic [NSP-1:0] all_hit, grant;
  logic           multi, any_hit;
  assign all_hit = {top_hit, bot_hit};

  rrm_priority #(.N(NSP)) u_pri (
    .hits  (all_hit),
    .grant (grant),
    .multi (multi),
    .any   (any_hit)
  );

  // Single output stage with valid/ready
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid        <= 1'b0;
      out_normal_valid <= 1'b0;
      out_row          <= '0;
      out_spare_sel    <= '0;
      out_multi_hit    <= 1'b0;
    end else begin
      if (take) begin
        out_valid        <= 1'b1;
        out_normal_valid <= !any_hit;
        out_row          <= in_row;
        out_spare_sel    <= grant;
        out_multi_hit    <= multi;
      end else if (out_ready) begin
        out_valid        <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rrm_checker.sv
module rrm_checker #(
  parameter int ROW_W    = 10,
  parameter int NSP      = 4,
  parameter int NBOT     = 2,
  parameter int BOT_ROWS = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [ROW_W-1:0] in_row,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_normal_valid,
  input logic [ROW_W-1:0] out_row,
  input logic [NSP-1:0]   out_spare_sel,
  input logic             out_multi_hit
);
  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_spare_sel));

  assert_multi_needs_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_multi_hit) |-> (out_spare_sel != '0));

  assert_normal_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_normal_valid == (out_spare_sel == '0)));

  assert_bottom_bank_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_row >= ROW_W'(BOT_ROWS)) |-> (out_spare_sel[NBOT-1:0] == '0));

  assert_top_bank_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_row < ROW_W'(BOT_ROWS)) |-> (out_spare_sel[NSP-1:NBOT] == '0));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_row_carried_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_row == $past(in_row)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row)
      && $stable(out_spare_sel) && $stable(out_normal_valid) && $stable(out_multi_hit)));

  assert_ready_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));
endmodule

bind rrm_spare_row_remap rrm_checker #(
  .ROW_W(ROW_W), .NSP(NSP), .NBOT(BOT_SPARES), .BOT_ROWS(BOT_ROWS)
) u_rrm_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
  .out_normal_valid(out_normal_valid), .out_row(out_row),
  .out_spare_sel(out_spare_sel), .out_multi_hit(out_multi_hit)
);

// File: tb/rrm_spare_row_remap_test.sv
module rrm_spare_row_remap_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_row = '0;
  logic [1:0]  bot_en = '0;
  logic [17:0] bot_addr = '0;
  logic [1:0]  top_en = '0;
  logic [1:0]  top_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_normal_valid;
  logic [9:0]  out_row;
  logic [3:0]  out_spare_sel;
  logic        out_multi_hit;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  rrm_spare_row_remap uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .bot_en(bot_en), .bot_addr(bot_addr),
    .top_en(top_en), .top_addr(top_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_normal_valid(out_normal_valid),
    .out_row(out_row), .out_spare_sel(out_spare_sel),
    .out_multi_hit(out_multi_hit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Arithmetic model of the requirements
  task automatic model(input int r, output logic [3:0] sel, output bit multi,
                       output string req);
    logic [3:0] hit;
    int n;
    bit shadow;
    hit = '0;
    shadow = 0;
    for (int k = 0; k < 2; k++) begin
      if (r < 512 && (r % 512) == int'(bot_addr[k*9 +: 9])) begin
        if (bot_en[k]) hit[k] = 1'b1; else shadow = 1;
      end
      if (r >= 512 && (r - 512) == int'(top_addr[k])) begin
        if (top_en[k]) hit[2+k] = 1'b1; else shadow = 1;
      end
    end
    n = $countones(hit);
    sel = '0;
    for (int k = 3; k >= 0; k--) if (hit[k]) sel = 4'b0001 << k;
    multi = (n > 1);
    if (n > 1)                req = "R6";
    else if (hit[1:0] != '0)  req = "R2";
    else if (hit[3:2] != '0)  req = "R4";
    else if (shadow)          req = "R5";
    else if (r >= 512)        req = "R3";
    else                      req = "R7";
  endtask

  task automatic access(input int r);
    logic [3:0] esel;
    bit emulti;
    string req;
    model(r, esel, emulti, req);
    in_valid = 1'b1;
    in_row   = r[9:0];
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8", "out_valid after accept", out_valid, 1);
    chk(out_row == r[9:0], "R10", "out_row", out_row, r);
    chk(out_spare_sel == esel, req, "spare select", out_spare_sel, esel);
    chk(out_normal_valid == (esel == '0), req, "normal flag", out_normal_valid, esel == '0);
    chk(out_multi_hit == emulti, req, "multi hit", out_multi_hit, emulti);
  endtask

  task automatic sweep();
    for (int r = 0; r < 514; r++) access(r);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid when idle", out_valid, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R7: nothing enabled
    sweep();

    // R2 R4: mixed repairs
    bot_en = 2'b11; bot_addr = {9'd300, 9'd5};
    top_en = 2'b01; top_addr = 2'b01;
    sweep();

    // R6: duplicated repairs in both banks
    bot_en = 2'b11; bot_addr = {9'd77, 9'd77};
    top_en = 2'b11; top_addr = 2'b00;
    sweep();

    // R3: bottom spares at the bank edges, top spares split
    bot_en = 2'b11; bot_addr = {9'd511, 9'd0};
    top_en = 2'b11; top_addr = 2'b01;
    sweep();

    // R5: addresses programmed, enables low
    bot_en = 2'b00; bot_addr = {9'd20, 9'd10};
    top_en = 2'b00; top_addr = 2'b10;
    sweep();

    // R9: back-pressure
    bot_en = 2'b01; bot_addr = {9'd0, 9'd5};
    out_ready = 1'b0;
    in_valid = 1'b1; in_row = 10'd5;
    @(posedge clk);
    @(negedge clk);
    in_row = 10'd6;
    chk(in_ready == 1'b0, "R9", "in_ready while stalled", in_ready, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R9", "out_valid held", out_valid, 1);
    chk(out_row == 10'd5, "R9", "out_row held", out_row, 5);
    chk(out_spare_sel == 4'b0001, "R9", "select held", out_spare_sel, 1);
    chk(in_ready == 1'b0, "R9", "in_ready still low", in_ready, 0);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R9", "in_ready on release", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_row == 10'd6, "R9", "next row after release", out_row, 6);
    chk(out_normal_valid == 1'b1, "R9", "next row normal", out_normal_valid, 1);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "drained", out_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule